// File: doc/BRIEF.md
# Windowed Modulo-N Up-Counter

This block is a synchronous binary up-counter that cycles through a window of values set by two parameters, a start value and a terminal value, instead of the full binary range. When the counter is enabled and sits on the terminal value, the next edge does not increment. It loads the start value instead, using the same synchronous load path as the external load strobe. No count is ever cleared asynchronously, so no glitch state appears on the outputs. With the default parameters the counter runs 9, 10, 11, 12, 13, 14 and back to 9, which is a modulo-6 sequence. A start value of 0 with a terminal value of N-1 gives a plain modulo-N counter.

An external load strobe writes any data word into the counter. That word may lie outside the window. In that case the counter keeps counting upward, rolls over from all ones to zero, and rejoins the window when it reaches the terminal value. Two flags, both combinational and both qualified by the count enable, mark the terminal value and the all-ones state. Elaboration stops with an error if the start value exceeds the terminal value or if either value does not fit the counter width.

Top module: `offset_modcnt`

## Requirements
- R1: Reset is synchronous and active high. On any edge where `rst` is 1, `count` becomes the start value (default 9), whatever `ld` and `cnt_en` are.
- R2: With `rst` 0 and `ld` 1, `count` takes `ld_data` on the edge, whatever `cnt_en` is and whatever the current count is.
- R3: With `rst`, `ld` and `cnt_en` all 0, `count` keeps its value.
- R4: With `rst` and `ld` 0 and `cnt_en` 1, a count that is not the terminal value increases by one. The all-ones value rolls over to 0.
- R5: With `rst` and `ld` 0 and `cnt_en` 1, a count equal to the terminal value (default 14) becomes the start value (default 9). From reset, the default free-running sequence is 9, 10, 11, 12, 13, 14, 9, and it repeats.
- R6: `term_hit` is 1 in the same cycle exactly when `cnt_en` is 1 and `count` equals the terminal value.
- R7: `carry_out` is 1 in the same cycle exactly when `cnt_en` is 1 and `count` is all ones (15 for 4 bits).
- R8: With a start value of 0 and a terminal value of 6, the free-running sequence is 0, 1, 2, 3, 4, 5, 6, 0, and `term_hit` is raised only on 6.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high, presets the start value |
| cnt_en | input | 1 | Count enable |
| ld | input | 1 | Load strobe, takes priority over counting |
| ld_data | input | W | Word captured when `ld` is 1 |
| count | output | W | Current count |
| carry_out | output | 1 | Enabled and count is all ones |
| term_hit | output | 1 | Enabled and count equals the terminal value |

## Verification
The bench drives every load value from 0 to 15, each followed by runs with the counter enabled and idle. This covers values below the window, values above it, and the all-ones rollover. A design that wrapped on an unqualified terminal compare would jump to the start value while it was meant to hold. A design whose load lost priority to the count would add one to a loaded word instead of keeping it.

The bench also asserts load and reset on the terminal value itself. It does this so that a wrong priority shows up as a start value where the loaded word belongs, or as a load where reset belongs.

A second instance with a zero preset and terminal 6 checks the modulo-7 case. Any design that wraps one step too early or too late stretches or shortens that cycle.

// File: rtl/modcnt_pkg.sv
package modcnt_pkg;

    // Next-state source chosen for the counter register, in priority order
    typedef enum logic [2:0] {
        ACT_RESET = 3'd0,
        ACT_LOAD  = 3'd1,
        ACT_WRAP  = 3'd2,
        ACT_INCR  = 3'd3,
        ACT_HOLD  = 3'd4
    } modcnt_act_e;

endpackage

// File: rtl/modcnt_flags.sv
module modcnt_flags #(
    parameter int W    = 4,
    parameter int TERM = 14
) (
    input  logic [W-1:0] cur,
    input  logic         cnt_en,
    output logic         at_term,
    output logic         term_hit,
    output logic         carry_out
);
    localparam logic [W-1:0] TERM_V = W'(TERM);
    localparam logic [W-1:0] ONES_V = {W{1'b1}};

    always_comb begin
        at_term   = (cur == TERM_V);
        term_hit  = cnt_en & at_term;
        carry_out = cnt_en & (cur == ONES_V);
    end
endmodule

// File: rtl/modcnt_ctrl.sv
module modcnt_ctrl
    import modcnt_pkg::*;
(
    input  logic        rst,
    input  logic        ld,
    input  logic        cnt_en,
    input  logic        at_term,
    output modcnt_act_e act
);
    always_comb begin
        if (rst)
            act = ACT_RESET;
        else if (ld)
            act = ACT_LOAD;
        else if (!cnt_en)
            act = ACT_HOLD;
        else if (at_term)
            act = ACT_WRAP;
        else
            act = ACT_INCR;
    end
endmodule

// File: rtl/modcnt_next.sv
module modcnt_next
    import modcnt_pkg::*;
#(
    parameter int W     = 4,
    parameter int START = 9
) (
    input  modcnt_act_e  act,
    input  logic [W-1:0] cur,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] nxt
);
    localparam logic [W-1:0] START_V = W'(START);

    // Reset and wrap share the single preset path
    always_comb begin
        case (act)
            ACT_RESET, ACT_WRAP: nxt = START_V;
            ACT_LOAD:            nxt = ld_data;
            ACT_INCR:            nxt = cur + 1'b1;
            default:             nxt = cur;
        endcase
    end
endmodule

// File: rtl/offset_modcnt.sv
module offset_modcnt
    import modcnt_pkg::*;
#(
    parameter int W     = 4,
    parameter int START = 9,
    parameter int TERM  = 14
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         cnt_en,
    input  logic         ld,
    input  logic [W-1:0] ld_data,
    output logic [W-1:0] count,
    output logic         carry_out,
    output logic         term_hit
);
    localparam int MAXV = (1 << W) - 1;

    generate
        if (START < 0 || START > TERM || TERM > MAXV) begin : g_bad_window
            $error("offset_modcnt: need 0 <= START <= TERM <= 2**W-1");
        end
    endgenerate

    typedef struct packed {
        logic [W-1:0] cnt;
    } cnt_state_t;

    cnt_state_t   st_d, st_q;
    modcnt_act_e  act;
    logic         at_term;
    logic [W-1:0] nxt;

    modcnt_flags #(.W(W), .TERM(TERM)) u_flags (
        .cur       (st_q.cnt),
        .cnt_en    (cnt_en),
        .at_term   (at_term),
        .term_hit  (term_hit),
        .carry_out (carry_out)
    );

    modcnt_ctrl u_ctrl (
        .rst     (rst),
        .ld      (ld),
        .cnt_en  (cnt_en),
        .at_term (at_term),
        .act     (act)
    );

    modcnt_next #(.W(W), .START(START)) u_next (
        .act     (act),
        .cur     (st_q.cnt),
        .ld_data (ld_data),
        .nxt     (nxt)
    );

    always_comb begin
        st_d     = st_q;
        st_d.cnt = nxt;
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    assign count = st_q.cnt;
endmodule

// File: rtl/offset_modcnt_chk.sv
module offset_modcnt_chk #(
    parameter int W     = 4,
    parameter int START = 9,
    parameter int TERM  = 14
) (
    input logic         clk,
    input logic         rst,
    input logic         cnt_en,
    input logic         ld,
    input logic [W-1:0] ld_data,
    input logic [W-1:0] count,
    input logic         carry_out,
    input logic         term_hit
);
    localparam logic [W-1:0] START_V = W'(START);
    localparam logic [W-1:0] TERM_V  = W'(TERM);

    a_r1_reset_preset: assert property (@(posedge clk)
        rst |=> count == START_V);

    a_r2_load_wins: assert property (@(posedge clk) disable iff (rst)
        ld |=> count == $past(ld_data));

    a_r3_hold_idle: assert property (@(posedge clk) disable iff (rst)
        (!ld && !cnt_en) |=> $stable(count));

    a_r4_step_up: assert property (@(posedge clk) disable iff (rst)
        (!ld && cnt_en && count != TERM_V) |=> count == W'($past(count) + 1'b1));

    a_r5_wrap_to_start: assert property (@(posedge clk) disable iff (rst)
        (!ld && term_hit) |=> count == START_V);

    a_r6_term_needs_enable: assert property (@(posedge clk) disable iff (rst)
        term_hit |-> cnt_en);

    a_r7_carry_rolls_over: assert property (@(posedge clk) disable iff (rst)
        (!ld && carry_out && !term_hit) |=> count == '0);
endmodule

bind offset_modcnt offset_modcnt_chk #(.W(W), .START(START), .TERM(TERM)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .cnt_en    (cnt_en),
    .ld        (ld),
    .ld_data   (ld_data),
    .count     (count),
    .carry_out (carry_out),
    .term_hit  (term_hit)
);

// File: tb/offset_modcnt_tb.sv
module offset_modcnt_tb;
    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cnt_en = 1'b0;
    logic       ld = 1'b0;
    logic [3:0] ld_data = '0;
    logic [3:0] count, count7;
    logic       carry_out, term_hit, carry7, term7;

    int checks = 0;
    int failures = 0;
    logic [3:0] exp_a = 4'd9;
    logic [3:0] exp_b = 4'd0;

    always #5 clk = ~clk;

    offset_modcnt #(.W(4), .START(9), .TERM(14)) u_dut (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld(ld), .ld_data(ld_data),
        .count(count), .carry_out(carry_out), .term_hit(term_hit)
    );

    offset_modcnt #(.W(4), .START(0), .TERM(6)) u_dut_m7 (
        .clk(clk), .rst(rst), .cnt_en(cnt_en), .ld(ld), .ld_data(ld_data),
        .count(count7), .carry_out(carry7), .term_hit(term7)
    );

    function automatic logic [3:0] model(input logic [3:0] cur, input logic r, input logic l,
                                         input logic e, input logic [3:0] d,
                                         input int start, input int term);
        if (r) return 4'(start);
        if (l) return d;
        if (!e) return cur;
        if (cur == 4'(term)) return 4'(start);
        return cur + 4'd1;
    endfunction

    function automatic string tag(input logic [3:0] cur, input logic r, input logic l,
                                  input logic e, input int term);
        if (r) return "R1";
        if (l) return "R2";
        if (!e) return "R3";
        if (cur == 4'(term)) return "R5";
        return "R4";
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic step(input logic r, input logic l, input logic e, input logic [3:0] d);
        string ta, tb;
        @(negedge clk);
        rst = r; ld = l; cnt_en = e; ld_data = d;
        #1;
        chk("R6 term_hit", int'(term_hit), int'(e && exp_a == 4'd14));
        chk("R7 carry_out", int'(carry_out), int'(e && exp_a == 4'd15));
        chk("R8 term_hit m7", int'(term7), int'(e && exp_b == 4'd6));
        ta = tag(exp_a, r, l, e, 14);
        tb = tag(exp_b, r, l, e, 6);
        exp_a = model(exp_a, r, l, e, d, 9, 14);
        exp_b = model(exp_b, r, l, e, d, 0, 6);
        @(posedge clk);
        #1;
        chk(ta, int'(count), int'(exp_a));
        chk({"R8 ", tb}, int'(count7), int'(exp_b));
    endtask

    initial begin : watchdog
        #1000000;
        failures++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin : stim
        // R1: reset presets start values
        step(1'b1, 1'b0, 1'b0, 4'd0);
        step(1'b1, 1'b0, 1'b1, 4'd3);
        // R5 / R8: free-running window sequences
        for (int i = 0; i < 20; i++) step(1'b0, 1'b0, 1'b1, 4'd0);
        // R2, R3, R4, R7: every load value, then idle and counting
        for (int v = 0; v < 16; v++) begin
            step(1'b0, 1'b1, v[0], 4'(v));
            step(1'b0, 1'b0, 1'b0, 4'd0);
            step(1'b0, 1'b0, 1'b0, 4'd5);
            for (int k = 0; k < 4; k++) step(1'b0, 1'b0, 1'b1, 4'd0);
            step(1'b0, 1'b1, 1'b1, 4'(15 - v));
        end
        // R2: load on the terminal value beats the wrap
        step(1'b0, 1'b1, 1'b0, 4'd14);
        step(1'b0, 1'b1, 1'b1, 4'd3);
        // R1: reset beats load on the terminal value
        step(1'b0, 1'b1, 1'b0, 4'd14);
        step(1'b1, 1'b1, 1'b1, 4'd2);
        // R3: idle on the terminal value does not wrap
        step(1'b0, 1'b1, 1'b0, 4'd14);
        step(1'b0, 1'b0, 1'b0, 4'd0);
        step(1'b0, 1'b0, 1'b1, 4'd0);
        // R8: one more full modulo-7 cycle from reset
        step(1'b1, 1'b0, 1'b0, 4'd0);
        for (int i = 0; i < 9; i++) step(1'b0, 1'b0, 1'b1, 4'd0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule